// File: doc/BRIEF.md
# Issue Scoreboard with Per-Class Latency Tracking

This block sits at the issue stage of a pipelined processor with 32 general registers. Each cycle it is shown one candidate instruction: two source register numbers, a destination register number, an operation class and a flag that marks a negative divide operand. It decides in the same cycle whether that instruction may issue or must stall. Every class has a fixed latency. A destination stays busy from the cycle after issue until the cycle its result is written back. In that write-back cycle the busy mark is already gone, so a waiting consumer issues then.

Two kinds of hazard come from shared hardware rather than from data. The first is the single write-back port. Each issued result books the port for its completion cycle. A later instruction that would finish in an already booked cycle is held back. The second is the floating-point unit. Its add and multiply pipelines accept a new operation every cycle and run independently of each other. A divide, however, holds the whole unit until it completes. Single-cycle ALU results are forwarded, so they never hold up a consumer.

Integer divide with a negative operand is not executed. It is accepted and a trap pulse is raised instead. It books nothing and marks nothing busy.

Top module: `issue_scoreboard`

## Requirements
- R1: Register 0 is never marked busy and never appears on the write-back output. A reference to it never causes a stall, and an operation that targets it books no write-back cycle.
- R2: A class 0 (ALU, latency 1) result is forwarded. A consumer of it presented in the next cycle issues with no stall. Class codes 9 to 15 behave as class 0.
- R3: The class codes and latencies are:
  - 1: integer multiply, 4 cycles
  - 2: integer divide, 39 cycles
  - 3: single add/sub/compare/convert, 5 cycles
  - 4: double add/sub/compare/convert, 6 cycles
  - 5: single multiply, 5 cycles
  - 6: double multiply, 10 cycles
  - 7: single divide, 30 cycles
  - 8: double divide, 60 cycles

  An operation of latency L that issues in cycle t shows wb_valid with its destination on wb_reg in cycle t+L.
- R4: The busy mark of a destination is clear in its write-back cycle. A dependent instruction presented in the cycle after the producer therefore stalls exactly L-1 cycles.
- R5: While either source or the destination of the presented instruction is busy, stall is high. This covers reads after writes and writes after writes.
- R6: The add pipeline (classes 3, 4) and the multiply pipeline (classes 1, 5, 6) are fully pipelined. Independent operations with free write-back cycles issue on consecutive cycles without stalling.
- R7: A divide (class 2, 7 or 8) occupies the floating-point unit from its issue cycle until its write-back cycle. In that window every operation of classes 1 to 8 stalls. ALU operations are unaffected.
- R8: When the write-back cycle of a presented operation is already booked by an older one, the presented operation stalls until its write-back cycle is free.
- R9: An issuing class 2 operation with req_neg high raises trap for that cycle. It marks nothing busy, books no write-back and does not occupy the unit.
- R10: After reset nothing is busy and nothing is booked. stall and trap are low whenever req_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A candidate instruction is presented |
| req_cls | input | 4 | Operation class code (see R3) |
| req_src_a | input | 5 | First source register |
| req_src_b | input | 5 | Second source register |
| req_dst | input | 5 | Destination register |
| req_neg | input | 1 | A divide operand is negative |
| stall | output | 1 | Presented instruction must wait |
| issue | output | 1 | Presented instruction is accepted this cycle |
| trap | output | 1 | Accepted integer divide with negative operand |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_reg | output | 5 | Register written back this cycle |
| busy | output | 32 | Per-register pending-write marks |

## Verification
A corrupted booking slot shows up at the ports in one of three ways, and always within the latency of the class concerned. A result may come out on wb_valid in the wrong cycle or for the wrong register. A busy mark may outlive its write-back, so a consumer stalls one cycle too many. A collision may be missed, so two results would claim the same cycle. A wrong divide occupancy count appears as an independent floating-point operation that issues earlier or later than L-1 cycles after the divide. Measuring the stall count and the write-back delay for every class therefore exposes an error in any single latency entry on the first dependent pair.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [3:0] {
    CLS_ALU    = 4'd0,
    CLS_IMUL   = 4'd1,
    CLS_IDIV   = 4'd2,
    CLS_FADD_S = 4'd3,
    CLS_FADD_D = 4'd4,
    CLS_FMUL_S = 4'd5,
    CLS_FMUL_D = 4'd6,
    CLS_FDIV_S = 4'd7,
    CLS_FDIV_D = 4'd8
  } op_cls_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // classes that need the floating-point unit (multiply, divide, add pipes)
  function automatic logic needs_fpu(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd8);
  endfunction

  function automatic logic is_divide(input logic [3:0] c);
    return (c == CLS_IDIV) || (c == CLS_FDIV_S) || (c == CLS_FDIV_D);
  endfunction

endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode #(
  parameter int LW         = 6,
  parameter int LAT_IMUL   = 4,
  parameter int LAT_IDIV   = 39,
  parameter int LAT_FADD_S = 5,
  parameter int LAT_FADD_D = 6,
  parameter int LAT_FMUL_S = 5,
  parameter int LAT_FMUL_D = 10,
  parameter int LAT_FDIV_S = 30,
  parameter int LAT_FDIV_D = 60
) (
  input  logic [3:0]    cls,
  output logic [LW-1:0] lat,
  output logic          uses_fpu,
  output logic          is_div
);
  import sb_pkg::*;

  always_comb begin
    case (cls)
      CLS_IMUL:   lat = LW'(LAT_IMUL);
      CLS_IDIV:   lat = LW'(LAT_IDIV);
      CLS_FADD_S: lat = LW'(LAT_FADD_S);
      CLS_FADD_D: lat = LW'(LAT_FADD_D);
      CLS_FMUL_S: lat = LW'(LAT_FMUL_S);
      CLS_FMUL_D: lat = LW'(LAT_FMUL_D);
      CLS_FDIV_S: lat = LW'(LAT_FDIV_S);
      CLS_FDIV_D: lat = LW'(LAT_FDIV_D);
      default:    lat = LW'(1);
    endcase
  end

  assign uses_fpu = needs_fpu(cls);
  assign is_div   = is_divide(cls);

endmodule

// File: rtl/sb_wb_queue.sv
// Booking line for the write-back port: slot k holds the result that
// returns k cycles after the current one. Slot 0 is this cycle's write.
module sb_wb_queue #(
  parameter int NREG  = 32,
  parameter int RW    = 5,
  parameter int DEPTH = 61,
  parameter int LW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [LW-1:0]   push_lat,
  input  logic [RW-1:0]   push_reg,
  input  logic [LW-1:0]   query_lat,
  output logic            query_hit,
  output logic            wb_valid,
  output logic [RW-1:0]   wb_reg,
  output logic [NREG-1:0] busy
);

  logic [DEPTH-1:0] slot_v;
  logic [RW-1:0]    slot_r [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int k = 0; k < DEPTH; k++) slot_r[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        slot_v[k] <= slot_v[k+1];
        slot_r[k] <= slot_r[k+1];
      end
      slot_v[DEPTH-1] <= 1'b0;
      if (push) begin
        slot_v[push_lat - LW'(1)] <= 1'b1;
        slot_r[push_lat - LW'(1)] <= push_reg;
      end
    end
  end

  assign query_hit = slot_v[query_lat];
  assign wb_valid  = slot_v[0];
  assign wb_reg    = slot_r[0];

  // pending but not yet returning: slots 1 and beyond
  always_comb begin
    busy = '0;
    for (int k = 1; k < DEPTH; k++)
      if (slot_v[k]) busy[slot_r[k]] = 1'b1;
  end

endmodule

// File: rtl/sb_div_track.sv
module sb_div_track #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_lat,
  output logic          active
);

  logic [LW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (start)            remain <= start_lat - LW'(1);
    else if (remain != '0)     remain <= remain - LW'(1);
  end

  assign active = (remain != '0);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NREG       = 32,
  parameter int LAT_IMUL   = 4,
  parameter int LAT_IDIV   = 39,
  parameter int LAT_FADD_S = 5,
  parameter int LAT_FADD_D = 6,
  parameter int LAT_FMUL_S = 5,
  parameter int LAT_FMUL_D = 10,
  parameter int LAT_FDIV_S = 30,
  parameter int LAT_FDIV_D = 60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [3:0]              req_cls,
  input  logic [$clog2(NREG)-1:0] req_src_a,
  input  logic [$clog2(NREG)-1:0] req_src_b,
  input  logic [$clog2(NREG)-1:0] req_dst,
  input  logic                    req_neg,
  output logic                    stall,
  output logic                    issue,
  output logic                    trap,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [NREG-1:0]         busy
);
  import sb_pkg::*;

  localparam int RW      = $clog2(NREG);
  localparam int MAX_LAT = imax(imax(imax(LAT_IMUL, LAT_IDIV), imax(LAT_FADD_S, LAT_FADD_D)),
                                imax(imax(LAT_FMUL_S, LAT_FMUL_D), imax(LAT_FDIV_S, LAT_FDIV_D)));
  localparam int DEPTH   = MAX_LAT + 1;
  localparam int LW      = $clog2(DEPTH);

  logic [LW-1:0] op_lat;
  logic          uses_fpu;
  logic          is_div;
  logic          port_taken;
  logic          div_active;
  logic          data_hazard;
  logic          unit_hazard;
  logic          port_hazard;
  logic          dst_real;
  logic          exec;

  sb_class_decode #(
    .LW(LW), .LAT_IMUL(LAT_IMUL), .LAT_IDIV(LAT_IDIV),
    .LAT_FADD_S(LAT_FADD_S), .LAT_FADD_D(LAT_FADD_D),
    .LAT_FMUL_S(LAT_FMUL_S), .LAT_FMUL_D(LAT_FMUL_D),
    .LAT_FDIV_S(LAT_FDIV_S), .LAT_FDIV_D(LAT_FDIV_D)
  ) u_dec (
    .cls(req_cls), .lat(op_lat), .uses_fpu(uses_fpu), .is_div(is_div)
  );

  assign dst_real    = (req_dst != '0);
  assign data_hazard = busy[req_src_a] | busy[req_src_b] | busy[req_dst];
  assign unit_hazard = uses_fpu & div_active;
  assign port_hazard = dst_real & port_taken;

  assign stall = req_valid & (data_hazard | unit_hazard | port_hazard);
  assign issue = req_valid & ~stall;
  assign trap  = issue & (req_cls == CLS_IDIV) & req_neg;
  assign exec  = issue & ~trap;

  sb_wb_queue #(.NREG(NREG), .RW(RW), .DEPTH(DEPTH), .LW(LW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(exec & dst_real), .push_lat(op_lat), .push_reg(req_dst),
    .query_lat(op_lat), .query_hit(port_taken),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .busy(busy)
  );

  sb_div_track #(.LW(LW)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(exec & is_div), .start_lat(op_lat), .active(div_active)
  );

endmodule

// File: rtl/issue_scoreboard_checker.sv
module issue_scoreboard_checker #(
  parameter int NREG = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [$clog2(NREG)-1:0] req_src_a,
  input logic [$clog2(NREG)-1:0] req_src_b,
  input logic [$clog2(NREG)-1:0] req_dst,
  input logic                    stall,
  input logic                    issue,
  input logic                    trap,
  input logic                    wb_valid,
  input logic [$clog2(NREG)-1:0] wb_reg,
  input logic [NREG-1:0]         busy,
  input logic                    uses_fpu,
  input logic                    is_div,
  input logic                    div_active
);

  assert_r0_never_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0]);

  assert_r0_no_writeback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_reg != '0));

  assert_wb_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !busy[wb_reg]);

  assert_busy_src_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (busy[req_src_a] || busy[req_src_b] || busy[req_dst])) |-> stall);

  assert_div_holds_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && uses_fpu && div_active) |-> stall);

  assert_div_takes_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_div && !trap) |=> div_active);

  assert_trap_on_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> issue);

  assert_trap_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !busy[$past(req_dst)]);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!stall && !trap));

endmodule

bind issue_scoreboard issue_scoreboard_checker #(.NREG(NREG)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
  .stall(stall), .issue(issue), .trap(trap),
  .wb_valid(wb_valid), .wb_reg(wb_reg), .busy(busy),
  .uses_fpu(uses_fpu), .is_div(is_div), .div_active(div_active)
);

// File: tb/issue_scoreboard_bench.sv
`timescale 1ns/1ps
module issue_scoreboard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cls = '0;
  logic [4:0]  req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic        req_neg = 1'b0;
  logic        stall, issue, trap, wb_valid;
  logic [4:0]  wb_reg;
  logic [31:0] busy;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  issue_scoreboard u_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
    .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
    .req_neg(req_neg), .stall(stall), .issue(issue), .trap(trap),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .busy(busy)
  );

  function automatic int exp_lat(input int c);
    case (c)
      1: return 4;
      2: return 39;
      3: return 5;
      4: return 6;
      5: return 5;
      6: return 10;
      7: return 30;
      8: return 60;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present an instruction, wait until it issues; report stall cycles and trap
  task automatic send(input int c, input int a, input int b, input int d,
                      input logic neg, output int stalls, output logic tr);
    @(negedge clk);
    req_valid = 1'b1; req_cls = 4'(c); req_src_a = 5'(a); req_src_b = 5'(b);
    req_dst = 5'(d); req_neg = neg;
    stalls = 0;
    #1;
    while (stall && stalls < 300) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    tr = trap;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_neg = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s;
    logic t;
    int k;
    int r0_wb;

    repeat (3) @(negedge clk);
    #1;
    check("R10 busy after reset", int'(busy), 0);
    check("R10 stall after reset", int'(stall), 0);
    check("R10 wb after reset", int'(wb_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: per-class dependent stall count and write-back delay
    for (int c = 0; c < 10; c++) begin
      send(c, 1, 2, 5, 1'b0, s, t);
      send(0, 5, 3, 6, 1'b0, s, t);
      if (c == 0) check("R2 forwarded consumer stalls", s, 0);
      else        check($sformatf("R4 dependent stall class %0d", c), s, exp_lat(c) - 1);
      idle(70);
      send(c, 1, 2, 9, 1'b0, s, t);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      k = 1;
      while (!(wb_valid && wb_reg == 5'd9) && k < 100) begin
        @(negedge clk);
        #1;
        k++;
      end
      check($sformatf("R3 writeback delay class %0d", c), k, exp_lat(c));
      idle(70);
    end

    // R5: write-after-write and second source
    send(4, 1, 2, 7, 1'b0, s, t);
    send(0, 1, 2, 7, 1'b0, s, t);
    check("R5 busy destination stall", s, 5);
    send(5, 1, 2, 19, 1'b0, s, t);
    send(0, 3, 19, 20, 1'b0, s, t);
    check("R5 busy second source stall", s, 4);
    idle(70);

    // R6: pipelined multiply and add
    send(5, 1, 2, 11, 1'b0, s, t); check("R6 mul 1", s, 0);
    send(5, 1, 2, 12, 1'b0, s, t); check("R6 mul 2", s, 0);
    send(5, 1, 2, 13, 1'b0, s, t); check("R6 mul 3", s, 0);
    send(4, 1, 2, 18, 1'b0, s, t); check("R6 add beside muls", s, 0);
    idle(70);

    // R7: divide holds the unit
    send(7, 1, 2, 8, 1'b0, s, t);
    send(3, 1, 2, 9, 1'b0, s, t);
    check("R7 add behind single divide", s, 29);
    idle(70);
    send(8, 1, 2, 8, 1'b0, s, t);
    send(0, 1, 2, 10, 1'b0, s, t);
    check("R7 ALU during divide", s, 0);
    send(1, 1, 2, 11, 1'b0, s, t);
    check("R7 int multiply behind double divide", s, 58);
    idle(70);

    // R8: write-back collision
    send(6, 1, 2, 14, 1'b0, s, t);
    for (int i = 0; i < 4; i++) send(0, 1, 2, 20 + i, 1'b0, s, t);
    send(3, 1, 2, 15, 1'b0, s, t);
    check("R8 collision stall", s, 1);
    idle(70);

    // R9: trapping divide
    send(2, 1, 2, 17, 1'b1, s, t);
    check("R9 trap raised", int'(t), 1);
    check("R9 trap no stall", s, 0);
    send(0, 17, 0, 21, 1'b0, s, t);
    check("R9 trapped dst not busy", s, 0);
    send(3, 1, 2, 22, 1'b0, s, t);
    check("R9 unit free after trap", s, 0);
    idle(70);

    // R1: register 0
    send(8, 1, 2, 0, 1'b0, s, t);
    send(0, 0, 0, 0, 1'b0, s, t);
    check("R1 r0 reference stall", s, 0);
    @(negedge clk);
    req_valid = 1'b0;
    r0_wb = 0;
    for (int i = 0; i < 70; i++) begin
      #1;
      if (wb_valid) r0_wb++;
      if (busy[0]) r0_wb++;
      @(negedge clk);
    end
    check("R1 no r0 writeback or busy", r0_wb, 0);
    #1;
    check("R10 idle no stall", int'(stall), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule